// File: doc/BRIEF.md
# Raster Scroll and Address Register Unit

This block holds the scroll and video-memory address state of a tile-based raster video processor. A processor writes bytes to a scroll port and to an address port. Both ports fill overlapping fields of one staged (temporary) register and share one first/second write phase. The live register drives the 15-bit address and scroll value that the pixel fetcher uses. A separate 3-bit fine horizontal offset drives the pixel shifter.

The live register changes in four ways. The second byte written to the address port commits the whole staged value. A data-port access made outside rendering steps the live value by 1 or by one row of 32. The renderer's strobes advance the horizontal and vertical counters, and copy the horizontal and vertical fields back from the staged value at the start of each line and each frame.

Both registers use the same layout, from the top bit down: fine Y [14:12], vertical page bit [11], horizontal page bit [10], coarse Y [9:5], coarse X [4:0].

Top module: `scroll_addr_unit`

## Requirements
- R1: After reset, `vaddr` and `fine_x` are zero and the write phase is "first".
- R2: A first-phase write to the address port (`wr_sel`=1) puts `wr_data[5:0]` into staged bits [13:8] and clears staged bit 14. The live value does not change.
- R3: A second-phase write to the address port puts `wr_data` into staged bits [7:0]. In the same clock it copies the whole staged value to `vaddr`.
- R4: A first-phase write to the scroll port (`wr_sel`=0) sets `fine_x` to `wr_data[2:0]` on the next clock and puts `wr_data[7:3]` into staged coarse X. `vaddr` does not change.
- R5: A second-phase write to the scroll port puts `wr_data[7:3]` into staged coarse Y and `wr_data[2:0]` into staged fine Y. `vaddr` does not change.
- R6: Both ports toggle one shared phase. The sequence address, scroll, scroll, address therefore sets every live bit, including fine Y values 4 to 7.
- R7: A pulse on `stat_rd` returns the write phase to "first".
- R8: When `render` is low, a data-port access steps `vaddr` by 1 (`step32`=0) or by 32 (`step32`=1), modulo 2^15. A data-port access is a write with `wr_sel`=2 or a pulse on `data_rd`. While `render` is high, the access has no effect on `vaddr`.
- R9: `h_inc` adds one to coarse X. When coarse X wraps from 31 to 0, the horizontal page bit flips.
- R10: `v_inc` adds one to fine Y. When fine Y overflows from 7, fine Y becomes 0 and coarse Y advances. Coarse Y wraps from VIS_ROWS-1 to 0 and flips the vertical page bit. It also wraps from 31 to 0, but that wrap leaves the page bit unchanged.
- R11: `h_copy` loads coarse X and the horizontal page bit from the staged value.
- R12: `v_copy` loads fine Y, coarse Y and the vertical page bit from the staged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Processor write strobe |
| wr_sel | input | 2 | Target: 0 scroll, 1 address, 2 data |
| wr_data | input | 8 | Write byte |
| data_rd | input | 1 | Data-port read strobe |
| stat_rd | input | 1 | Status read strobe, clears the write phase |
| step32 | input | 1 | Data-access step: 0 for +1, 1 for +32 |
| render | input | 1 | High while the renderer owns the counters |
| h_inc | input | 1 | Advance coarse X |
| v_inc | input | 1 | Advance fine Y / coarse Y |
| h_copy | input | 1 | Reload horizontal fields from staged value |
| v_copy | input | 1 | Reload vertical fields from staged value |
| vaddr | output | 15 | Live address / scroll value |
| fine_x | output | 3 | Fine horizontal offset |

## Verification
The bench builds the unit with the default VIS_ROWS of 30. With that value the live-row wrap at 29, which flips the page bit, can be told apart from the wrap at 31, which runs through the attribute rows and leaves the page bit alone. The staged register can only be seen through commits and copies, so each staged-field check is a write sequence followed by `v_copy`, `h_copy`, or a second address write. A start at 0x7FFF, built with the four-write sequence, brings the 15-bit data-step wrap within reach.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  localparam int DATA_W   = 8;
  localparam int FINE_W   = 3;
  localparam int COARSE_W = 5;
  localparam int REG_W    = FINE_W + 2 + 2 * COARSE_W;

  typedef enum logic [1:0] {
    SEL_SCROLL = 2'd0,
    SEL_ADDR   = 2'd1,
    SEL_DATA   = 2'd2
  } port_sel_e;

  typedef struct packed {
    logic [FINE_W-1:0]   fy;
    logic                pg_v;
    logic                pg_h;
    logic [COARSE_W-1:0] cy;
    logic [COARSE_W-1:0] cx;
  } scroll_t;
endpackage

// File: rtl/scroll_write_ctl.sv
module scroll_write_ctl
  import scroll_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                stat_rd,
  output scroll_t             stage,
  output scroll_t             stage_nxt,
  output logic [FINE_W-1:0]   fine_x,
  output logic                phase2,
  output logic                commit
);
  logic scroll_wr, addr_wr, stage_en, fx_en;
  logic phase_nxt;
  logic [FINE_W-1:0] fx_nxt;

  assign scroll_wr = wr_en && (wr_sel == SEL_SCROLL);
  assign addr_wr   = wr_en && (wr_sel == SEL_ADDR);
  assign stage_en  = scroll_wr || addr_wr;
  assign fx_en     = scroll_wr && !phase2;

  always_comb begin
    stage_nxt = stage;
    fx_nxt    = fine_x;
    phase_nxt = phase2;
    commit    = 1'b0;
    if (scroll_wr) begin
      if (!phase2) begin
        stage_nxt.cx = wr_data[7:3];
        fx_nxt       = wr_data[2:0];
      end else begin
        stage_nxt.cy = wr_data[7:3];
        stage_nxt.fy = wr_data[2:0];
      end
      phase_nxt = !phase2;
    end else if (addr_wr) begin
      if (!phase2) begin
        {stage_nxt.fy[1:0], stage_nxt.pg_v, stage_nxt.pg_h, stage_nxt.cy[4:3]} = wr_data[5:0];
        stage_nxt.fy[2] = 1'b0;
      end else begin
        {stage_nxt.cy[2:0], stage_nxt.cx} = wr_data;
        commit = 1'b1;
      end
      phase_nxt = !phase2;
    end
    if (stat_rd) phase_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage  <= '0;
      fine_x <= '0;
      phase2 <= 1'b0;
    end else begin
      if (stage_en) stage  <= stage_nxt;
      if (fx_en)    fine_x <= fx_nxt;
      phase2 <= phase_nxt;
    end
  end

  // R2: first address byte always leaves top fine-Y bit clear
  p_top_fy_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !phase2 && !scroll_wr) |=> (stage.fy[2] == 1'b0));

  // R7: status read returns to first phase
  p_phase_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !phase2);
endmodule

// File: rtl/scroll_live_ctr.sv
module scroll_live_ctr
  import scroll_pkg::*;
#(
  parameter int VIS_ROWS = 30
) (
  input  logic    clk,
  input  logic    rst_n,
  input  scroll_t stage,
  input  scroll_t stage_nxt,
  input  logic    commit,
  input  logic    step_en,
  input  logic    step32,
  input  logic    h_inc,
  input  logic    v_inc,
  input  logic    h_copy,
  input  logic    v_copy,
  output scroll_t cur
);
  localparam logic [COARSE_W-1:0] LAST_ROW = COARSE_W'(VIS_ROWS - 1);
  localparam logic [COARSE_W-1:0] MAX_C    = {COARSE_W{1'b1}};
  localparam logic [FINE_W-1:0]   MAX_F    = {FINE_W{1'b1}};
  localparam logic [REG_W-1:0]    ROW_STEP = REG_W'(1 << COARSE_W);

  scroll_t cur_nxt;
  logic    cur_en;
  logic [REG_W-1:0] step_amt;

  assign step_amt = step32 ? ROW_STEP : REG_W'(1);
  assign cur_en   = commit || step_en || h_inc || v_inc || h_copy || v_copy;

  always_comb begin
    cur_nxt = cur;
    if (commit) begin
      cur_nxt = stage_nxt;
    end else if (step_en) begin
      cur_nxt = scroll_t'(cur + step_amt);
    end else begin
      if (h_copy) begin
        cur_nxt.cx   = stage.cx;
        cur_nxt.pg_h = stage.pg_h;
      end else if (h_inc) begin
        if (cur.cx == MAX_C) begin
          cur_nxt.cx   = '0;
          cur_nxt.pg_h = !cur.pg_h;
        end else begin
          cur_nxt.cx = cur.cx + 1'b1;
        end
      end
      if (v_copy) begin
        cur_nxt.fy   = stage.fy;
        cur_nxt.pg_v = stage.pg_v;
        cur_nxt.cy   = stage.cy;
      end else if (v_inc) begin
        if (cur.fy != MAX_F) begin
          cur_nxt.fy = cur.fy + 1'b1;
        end else begin
          cur_nxt.fy = '0;
          if (cur.cy == LAST_ROW) begin
            cur_nxt.cy   = '0;
            cur_nxt.pg_v = !cur.pg_v;
          end else if (cur.cy == MAX_C) begin
            cur_nxt.cy = '0;
          end else begin
            cur_nxt.cy = cur.cy + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= '0;
    else if (cur_en) cur <= cur_nxt;
  end

  // R9: coarse X wrap flips horizontal page
  p_hwrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_inc && !h_copy && !commit && !step_en && cur.cx == MAX_C)
      |=> (cur.cx == '0 && cur.pg_h != $past(cur.pg_h)));

  // R10: wrap from the top attribute row keeps the vertical page
  p_vwrap_attr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (v_inc && !v_copy && !commit && !step_en && cur.fy == MAX_F && cur.cy == MAX_C)
      |=> (cur.cy == '0 && cur.pg_v == $past(cur.pg_v)));

  // R10: wrap from the last visible row flips the vertical page
  p_vwrap_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (v_inc && !v_copy && !commit && !step_en && cur.fy == MAX_F && cur.cy == LAST_ROW)
      |=> (cur.cy == '0 && cur.pg_v != $past(cur.pg_v)));
endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
  import scroll_pkg::*;
#(
  parameter int VIS_ROWS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              data_rd,
  input  logic              stat_rd,
  input  logic              step32,
  input  logic              render,
  input  logic              h_inc,
  input  logic              v_inc,
  input  logic              h_copy,
  input  logic              v_copy,
  output logic [14:0]       vaddr,
  output logic [2:0]        fine_x
);
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  scroll_t    stage, stage_nxt, cur;
  logic       phase2, commit, step_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  assign step_en = !render && (data_rd || (wr_en && wr_sel == SEL_DATA));

  scroll_write_ctl u_wr (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .stat_rd(stat_rd), .stage(stage),
    .stage_nxt(stage_nxt), .fine_x(fine_x), .phase2(phase2), .commit(commit)
  );

  scroll_live_ctr #(.VIS_ROWS(VIS_ROWS)) u_live (
    .clk(clk), .rst_n(rst_q_n), .stage(stage), .stage_nxt(stage_nxt),
    .commit(commit), .step_en(step_en), .step32(step32),
    .h_inc(h_inc), .v_inc(v_inc), .h_copy(h_copy), .v_copy(v_copy),
    .cur(cur)
  );

  assign vaddr = cur;

  // R3: second address byte lands in the live low byte
  p_commit_low_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_sel == SEL_ADDR && phase2) |=> (vaddr[7:0] == $past(wr_data)));

  // R4: first scroll byte sets fine X at once
  p_fine_x_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_sel == SEL_SCROLL && !phase2) |=> (fine_x == $past(wr_data[2:0])));

  // R5: scroll writes alone never move the live value
  p_scroll_hold_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_sel == SEL_SCROLL && !data_rd && !h_inc && !v_inc && !h_copy && !v_copy)
      |=> $stable(vaddr));

  // R8: a data access during rendering leaves the live value alone
  p_render_hold_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (render && data_rd && !wr_en && !h_inc && !v_inc && !h_copy && !v_copy)
      |=> $stable(vaddr));
endmodule

// File: tb/scroll_addr_unit_test.sv
module scroll_addr_unit_test;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, data_rd, stat_rd, step32, render;
  logic h_inc, v_inc, h_copy, v_copy;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [14:0] vaddr;
  logic [2:0] fine_x;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  scroll_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .data_rd(data_rd), .stat_rd(stat_rd), .step32(step32), .render(render),
    .h_inc(h_inc), .v_inc(v_inc), .h_copy(h_copy), .v_copy(v_copy),
    .vaddr(vaddr), .fine_x(fine_x)
  );

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic hi, input logic vi, input logic hc, input logic vc);
    @(negedge clk);
    h_inc = hi; v_inc = vi; h_copy = hc; v_copy = vc;
    @(negedge clk);
    h_inc = 1'b0; v_inc = 1'b0; h_copy = 1'b0; v_copy = 1'b0;
  endtask

  task automatic status_read();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic data_read(input logic s32, input logic rend);
    @(negedge clk); data_rd = 1'b1; step32 = s32; render = rend;
    @(negedge clk); data_rd = 1'b0; render = 1'b0;
  endtask

  task automatic load_full(input logic [7:0] a1, input logic [7:0] s2,
                           input logic [7:0] s1, input logic [7:0] a2);
    status_read();
    cpu_wr(2'd1, a1); cpu_wr(2'd0, s2); cpu_wr(2'd0, s1); cpu_wr(2'd1, a2);
  endtask

  task automatic t_reset();
    check("R1 vaddr", vaddr, 15'h0000);
    check("R1 fine_x", {12'd0, fine_x}, 15'd0);
  endtask

  task automatic t_addr();
    cpu_wr(2'd1, 8'hFF);
    check("R2 no live change", vaddr, 15'h0000);
    cpu_wr(2'd1, 8'h00);
    check("R3 commit, R2 bit14 clear", vaddr, 15'h3F00);
  endtask

  task automatic t_scroll();
    cpu_wr(2'd0, 8'hAD);
    check("R4 fine_x", {12'd0, fine_x}, 15'd5);
    check("R4 live hold", vaddr, 15'h3F00);
    cpu_wr(2'd0, 8'h5E);
    check("R5 live hold", vaddr, 15'h3F00);
    pulse(1'b0, 1'b0, 1'b0, 1'b1);
    check("R12 vertical copy", vaddr, 15'h6D60);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    check("R11 horizontal copy", vaddr, 15'h6D75);
  endtask

  task automatic t_four_write();
    load_full(8'h08, 8'hC7, 8'h03, 8'h65);
    check("R6 full value", vaddr, 15'h7B65);
    check("R6 fine_x", {12'd0, fine_x}, 15'd3);
  endtask

  task automatic t_status();
    cpu_wr(2'd1, 8'h00);
    status_read();
    cpu_wr(2'd1, 8'h12);
    cpu_wr(2'd1, 8'h34);
    check("R7 phase reset", vaddr, 15'h1234);
  endtask

  task automatic t_step();
    status_read();
    cpu_wr(2'd1, 8'h7F); cpu_wr(2'd1, 8'hFF);
    data_read(1'b0, 1'b0);
    check("R8 step 1", vaddr, 15'h4000);
    load_full(8'h3F, 8'hFF, 8'hF8, 8'hFF);
    cpu_wr(2'd2, 8'h00);
    check("R8 step 1 from write", vaddr, 15'h0000);
    load_full(8'h3F, 8'hFF, 8'hF8, 8'hFF);
    step32 = 1'b1;
    cpu_wr(2'd2, 8'h00);
    step32 = 1'b0;
    check("R8 step 32 wrap", vaddr, 15'h001F);
    data_read(1'b0, 1'b1);
    check("R8 ignored in render", vaddr, 15'h001F);
    data_read(1'b0, 1'b0);
    check("R8 step after render", vaddr, 15'h0020);
  endtask

  task automatic t_hinc();
    status_read();
    cpu_wr(2'd1, 8'h00); cpu_wr(2'd1, 8'h1E);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    check("R9 increment", vaddr, 15'h001F);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    check("R9 wrap flips page", vaddr, 15'h0400);
  endtask

  task automatic t_vinc();
    load_full(8'h00, 8'hEF, 8'h00, 8'hA0);
    check("R10 setup", vaddr, 15'h73A0);
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 wrap at last row", vaddr, 15'h0800);
    load_full(8'h00, 8'hFF, 8'h00, 8'hE0);
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 wrap at row 31", vaddr, 15'h0000);
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 fine step", vaddr, 15'h1000);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'h00;
    data_rd = 1'b0; stat_rd = 1'b0; step32 = 1'b0; render = 1'b0;
    h_inc = 1'b0; v_inc = 1'b0; h_copy = 1'b0; v_copy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_addr();
    t_scroll();
    t_four_write();
    t_status();
    t_step();
    t_hinc();
    t_vinc();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule